// File: doc/BRIEF.md
# Sliced Variable-Node Sum Accumulator

This block keeps the running soft value of one variable node while a decoder walks through the row slices of a parity-check matrix, one slice after another, inside each iteration. For every slice it adds the check-to-variable messages that land on this column to the value left by the previous slice. Memory addressing and the check-node side are handled elsewhere. The caller supplies the previous running value and gets the updated one back.

On the first slice in which the column takes part during an iteration, the intrinsic channel value replaces the previous running value as the starting point. On the last such slice the block also issues the hard decision, which is the sign of the updated sum. A slice column may hold several ones. Each of these is one message lane, enabled by its own bit in a lane mask, and there is one adder per lane. The adder chain is purely combinational and its result lands in a single output register. The running value is two bits wider than the messages and saturates at its limits.

Top module: `vn_slice_accum`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `hd_valid`, `hd_bit` and `sum_out` are all driven to 0 after that edge.
- R2: A slice applied with `in_valid` high at a rising edge produces its result on `sum_out` with `out_valid` high after that same edge, which is one register stage with no further delay.
- R3: When `first_slice` is low, the new sum equals `prev_sum` plus every enabled message. All values are two's complement, and lane k of `r_msgs` occupies bits [k*MSG_W +: MSG_W].
- R4: When `first_slice` is high, the sign-extended `intrinsic` takes the place of `prev_sum`, and `prev_sum` has no effect on the result.
- R5: A lane whose `edge_mask` bit (bit k for lane k) is 0 contributes nothing, whatever value it carries.
- R6: The sum is held to SUM_W = MSG_W + 2 bits. A true total above 2^(SUM_W-1)-1 gives that maximum, and one below -2^(SUM_W-1) gives that minimum.
- R7: A slice applied with `last_slice` high raises `hd_valid` for exactly the one result cycle. In that cycle `hd_bit` equals the sign bit of the new sum, where 1 means negative.
- R8: A slice without `last_slice` gives `hd_valid` low and leaves `hd_bit` at its previous value.
- R9: In a cycle after an edge with `in_valid` low, `out_valid` and `hd_valid` are low, and `sum_out` and `hd_bit` keep their values.
- R10: With an all-zero `edge_mask`, the result equals the starting value. That is `prev_sum`, or the sign-extended `intrinsic` when `first_slice` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A slice update is applied this cycle |
| first_slice | input | 1 | Column's first slice in this iteration: seed from intrinsic |
| last_slice | input | 1 | Column's last slice in this iteration: issue hard decision |
| edge_mask | input | LANES | Per-lane enable, bit k for lane k |
| r_msgs | input | LANES*MSG_W | Check-to-variable messages, lane k at bits k*MSG_W |
| intrinsic | input | MSG_W | Intrinsic channel value of the column |
| prev_sum | input | SUM_W | Running value left by the previous slice |
| out_valid | output | 1 | `sum_out` holds a new result |
| sum_out | output | SUM_W | Updated running value, saturated |
| hd_valid | output | 1 | `hd_bit` holds this iteration's decision |
| hd_bit | output | 1 | Hard decision, 1 for a negative sum |

## Verification
The accumulator is driven with a chained iteration that feeds each result back as the next `prev_sum`. This shows that seeding, accumulation and the final decision work together across slices. Vectors that set `first_slice` with a large `prev_sum` confirm that the previous term is replaced and not added. Vectors that put large values on masked-off lanes confirm that disabled lanes are dropped. Totals driven just past both limits distinguish saturation from wrap-around. A long run of mixed random vectors with idle gaps checks that the decision strobe and the held outputs behave when no slice is applied.

// File: rtl/vnacc_pkg.sv
package vnacc_pkg;

    localparam int MSG_W_DEFAULT = 7;
    localparam int SUM_GUARD     = 2;
    localparam int LANES_DEFAULT = 3;

    typedef enum logic {
        BASE_PREV = 1'b0,
        BASE_INTR = 1'b1
    } base_sel_e;

    typedef struct packed {
        logic vld;
        logic hdv;
        logic hd;
    } out_flags_t;

    function automatic base_sel_e pick_base(input logic first);
        return first ? BASE_INTR : BASE_PREV;
    endfunction

endpackage

// File: rtl/vnacc_seed_mux.sv
module vnacc_seed_mux
    import vnacc_pkg::*;
#(
    parameter int MSG_W = 7,
    parameter int SUM_W = 9,
    parameter int ACC_W = 12
) (
    input  base_sel_e         sel,
    input  logic [MSG_W-1:0]  intrinsic,
    input  logic [SUM_W-1:0]  prev_sum,
    output logic [ACC_W-1:0]  base_ext
);
    localparam int INTR_PAD = ACC_W - MSG_W;
    localparam int PREV_PAD = ACC_W - SUM_W;

    always_comb begin
        if (sel == BASE_INTR)
            base_ext = {{INTR_PAD{intrinsic[MSG_W-1]}}, intrinsic};
        else
            base_ext = {{PREV_PAD{prev_sum[SUM_W-1]}}, prev_sum};
    end
endmodule

// File: rtl/vnacc_adder_chain.sv
module vnacc_adder_chain #(
    parameter int MSG_W = 7,
    parameter int LANES = 3,
    parameter int ACC_W = 12
) (
    input  logic [ACC_W-1:0]       base_ext,
    input  logic [LANES-1:0]       lane_en,
    input  logic [LANES*MSG_W-1:0] lanes,
    output logic [ACC_W-1:0]       total
);
    localparam int PAD = ACC_W - MSG_W;

    logic [ACC_W-1:0] part [0:LANES];
    assign part[0] = base_ext;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [MSG_W-1:0] msg;
        logic [ACC_W-1:0] term;
        assign msg  = lanes[k*MSG_W +: MSG_W];
        assign term = lane_en[k] ? {{PAD{msg[MSG_W-1]}}, msg} : '0;
        assign part[k+1] = part[k] + term;
    end

    assign total = part[LANES];
endmodule

// File: rtl/vnacc_saturate.sv
module vnacc_saturate #(
    parameter int SUM_W = 9,
    parameter int ACC_W = 12
) (
    input  logic [ACC_W-1:0] acc,
    output logic [SUM_W-1:0] sat
);
    localparam int TOP_W = ACC_W - SUM_W + 1;

    logic [TOP_W-1:0] top_bits;
    logic             fits;

    assign top_bits = acc[ACC_W-1:SUM_W-1];
    assign fits     = (top_bits == '0) || (top_bits == '1);

    always_comb begin
        if (fits)
            sat = acc[SUM_W-1:0];
        else if (acc[ACC_W-1])
            sat = {1'b1, {(SUM_W-1){1'b0}}};
        else
            sat = {1'b0, {(SUM_W-1){1'b1}}};
    end
endmodule

// File: rtl/vn_slice_accum.sv
module vn_slice_accum
    import vnacc_pkg::*;
#(
    parameter int MSG_W = MSG_W_DEFAULT,
    parameter int LANES = LANES_DEFAULT,
    parameter int SUM_W = MSG_W + SUM_GUARD
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic                   first_slice,
    input  logic                   last_slice,
    input  logic [LANES-1:0]       edge_mask,
    input  logic [LANES*MSG_W-1:0] r_msgs,
    input  logic [MSG_W-1:0]       intrinsic,
    input  logic [SUM_W-1:0]       prev_sum,
    output logic                   out_valid,
    output logic [SUM_W-1:0]       sum_out,
    output logic                   hd_valid,
    output logic                   hd_bit
);
    localparam int ACC_W = SUM_W + $clog2(LANES + 1) + 1;

    logic [ACC_W-1:0] base_ext;
    logic [ACC_W-1:0] total;
    logic [SUM_W-1:0] sat_sum;
    logic [SUM_W-1:0] sum_q;
    out_flags_t       flags_q;

    vnacc_seed_mux #(.MSG_W(MSG_W), .SUM_W(SUM_W), .ACC_W(ACC_W)) u_seed (
        .sel       (pick_base(first_slice)),
        .intrinsic (intrinsic),
        .prev_sum  (prev_sum),
        .base_ext  (base_ext)
    );

    vnacc_adder_chain #(.MSG_W(MSG_W), .LANES(LANES), .ACC_W(ACC_W)) u_chain (
        .base_ext (base_ext),
        .lane_en  (edge_mask),
        .lanes    (r_msgs),
        .total    (total)
    );

    vnacc_saturate #(.SUM_W(SUM_W), .ACC_W(ACC_W)) u_sat (
        .acc (total),
        .sat (sat_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q   <= '0;
            flags_q <= '0;
        end else begin
            flags_q.vld <= in_valid;
            flags_q.hdv <= in_valid && last_slice;
            if (in_valid) begin
                sum_q <= sat_sum;
                if (last_slice)
                    flags_q.hd <= sat_sum[SUM_W-1];
            end
        end
    end

    assign sum_out   = sum_q;
    assign out_valid = flags_q.vld;
    assign hd_valid  = flags_q.hdv;
    assign hd_bit    = flags_q.hd;

    // R7: the decision strobe only follows a slice marked last
    p_hd_only_last_r7: assert property (@(posedge clk) disable iff (rst)
        hd_valid |-> (out_valid && $past(last_slice)));

    // R7: the decision carries the sign of the result
    p_hd_sign_r7: assert property (@(posedge clk) disable iff (rst)
        hd_valid |-> (hd_bit == sum_out[SUM_W-1]));

    // R9: without an applied slice the outputs hold
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> ($stable(sum_out) && !hd_valid && $stable(hd_bit)));

    // R10: empty mask, not first: previous value passes through
    p_empty_pass_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(edge_mask == '0) && !$past(first_slice))
        |-> (sum_out == $past(prev_sum)));

    // R4: empty mask, first: intrinsic seeds the result
    p_first_seed_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(edge_mask == '0) && $past(first_slice))
        |-> (sum_out == {{(SUM_W-MSG_W){$past(intrinsic[MSG_W-1])}}, $past(intrinsic)}));

endmodule

// File: tb/tb_vn_slice_accum.sv
module tb_vn_slice_accum;
    localparam int MSG_W = 7;
    localparam int LANES = 3;
    localparam int SUM_W = 9;
    localparam int SMAX  = 255;
    localparam int SMIN  = -256;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   in_valid = 1'b0;
    logic                   first_slice = 1'b0;
    logic                   last_slice = 1'b0;
    logic [LANES-1:0]       edge_mask = '0;
    logic [LANES*MSG_W-1:0] r_msgs = '0;
    logic [MSG_W-1:0]       intrinsic = '0;
    logic [SUM_W-1:0]       prev_sum = '0;
    logic                   out_valid;
    logic [SUM_W-1:0]       sum_out;
    logic                   hd_valid;
    logic                   hd_bit;

    vn_slice_accum #(.MSG_W(MSG_W), .LANES(LANES), .SUM_W(SUM_W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .first_slice(first_slice),
        .last_slice(last_slice), .edge_mask(edge_mask), .r_msgs(r_msgs),
        .intrinsic(intrinsic), .prev_sum(prev_sum), .out_valid(out_valid),
        .sum_out(sum_out), .hd_valid(hd_valid), .hd_bit(hd_bit)
    );

    always #10 clk = ~clk;

    typedef struct {
        int    sum;
        bit    hdv;
        bit    hd;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec  = 0;
    int   n_bad  = 0;
    bit   model_hd = 1'b0;
    int   mon_sum  = 0;
    bit   mon_hd   = 1'b0;
    int   last_out = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int clamp(input int v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    task automatic send(input bit f, input bit l, input logic [2:0] m,
                        input int r0, input int r1, input int r2,
                        input int intr, input int prev, input string tag);
        exp_t e;
        int   acc;
        @(negedge clk);
        in_valid    = 1'b1;
        first_slice = f;
        last_slice  = l;
        edge_mask   = m;
        r_msgs      = {7'(r2), 7'(r1), 7'(r0)};
        intrinsic   = 7'(intr);
        prev_sum    = 9'(prev);
        acc = f ? intr : prev;
        if (m[0]) acc += r0;
        if (m[1]) acc += r1;
        if (m[2]) acc += r2;
        e.sum = clamp(acc);
        e.hdv = l;
        if (l) model_hd = (e.sum < 0);
        e.hd  = model_hd;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            prev_sum = 9'h0AA;
            edge_mask = '1;
        end
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'($signed(sum_out)) == e.sum, {e.tag, " sum"},
                          int'($signed(sum_out)), e.sum);
                    check(hd_valid == e.hdv, {e.tag, " R7/R8 hd_valid"}, hd_valid, e.hdv);
                    check(hd_bit == e.hd, {e.tag, " R7/R8 hd_bit"}, hd_bit, e.hd);
                    mon_sum = e.sum;
                    mon_hd  = e.hd;
                    last_out = int'($signed(sum_out));
                end
            end else begin
                check(hd_valid == 1'b0, "R9 hd_valid idle", hd_valid, 0);
                check(int'($signed(sum_out)) == mon_sum, "R9 sum hold",
                      int'($signed(sum_out)), mon_sum);
                check(hd_bit == mon_hd, "R9 hd_bit hold", hd_bit, mon_hd);
            end
        end
    end

    initial begin
        int w = 0;
        while (w < 100000) begin
            @(posedge clk);
            w++;
        end
        check(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(hd_valid == 1'b0, "R1 hd_valid", hd_valid, 0);
        check(hd_bit == 1'b0, "R1 hd_bit", hd_bit, 0);
        check(sum_out == '0, "R1 sum_out", int'(sum_out), 0);
        rst = 1'b0;

        // R3: plain accumulation
        send(0, 0, 3'b111, 5, -3, 10, 0, 20, "R3 all lanes");
        send(0, 0, 3'b001, -7, 0, 0, 0, -40, "R3 one lane");
        // R4: seeding ignores prev_sum
        send(1, 0, 3'b011, 4, 6, 0, -12, 200, "R4 seed");
        send(1, 0, 3'b000, 0, 0, 0, -64, 111, "R4 R10 seed empty");
        // R5: masked lanes carry large junk
        send(0, 0, 3'b010, 63, 9, -64, 0, 1, "R5 mask");
        // R10: empty mask passthrough
        send(0, 0, 3'b000, 50, 50, 50, 30, -200, "R10 empty");
        // R6: saturation both ways
        send(0, 0, 3'b111, 63, 63, 63, 0, 250, "R6 high");
        send(0, 0, 3'b111, -64, -64, -64, 0, -256, "R6 low");
        send(0, 0, 3'b110, 0, 63, -64, 0, 255, "R6 edge no sat");
        // R7: decisions
        send(0, 1, 3'b101, -20, 0, -1, 0, 5, "R7 last negative");
        idle(2);
        send(0, 1, 3'b001, 0, 0, 0, 0, 0, "R7 last zero");
        send(0, 0, 3'b111, -60, -60, -60, 0, 0, "R8 no last holds hd");
        idle(3);

        // R2 chained iteration: feed each result back as prev_sum
        send(1, 0, 3'b011, 10, -4, 0, -30, 0, "R2 chain first");
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk); #1;
        send(0, 0, 3'b111, 8, 8, 8, 0, last_out, "R2 chain mid");
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk); #1;
        send(0, 1, 3'b100, 0, 0, 33, 0, last_out, "R2 chain last");
        idle(2);

        // mixed random vectors
        for (int i = 0; i < 300; i++) begin
            int r0, r1, r2, it, pv;
            r0 = int'($urandom_range(0, 127)) - 64;
            r1 = int'($urandom_range(0, 127)) - 64;
            r2 = int'($urandom_range(0, 127)) - 64;
            it = int'($urandom_range(0, 127)) - 64;
            pv = int'($urandom_range(0, 511)) - 256;
            send(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                 3'($urandom_range(0, 7)), r0, r1, r2, it, pv, "R3 R5 random");
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(4);
        check(exp_q.size() == 0, "R2 results drained", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule